// File: doc/BRIEF.md
# Instruction Retirement Countdown Trigger

This block is a debug trigger that counts retired instructions down to zero and then asks the hart for a breakpoint. Software loads a control word that holds a 14-bit remaining count together with five privilege-enable bits. After that, each retire strobe that arrives while the hart runs in an enabled privilege mode takes one off the count. When the count goes from one to zero, the block emits a single-cycle fire pulse. The hart turns that pulse into a breakpoint exception.

The count lives inside the control word itself. A read of the control word therefore always shows the live remaining count. A count of zero makes the trigger inactive. Retirements in modes whose enable bit is clear are simply not counted. The action, hit, pending and debug-mode-only fields are not implemented and read as zero. The type field always reads as instruction-count. Writes aimed at the second and third data registers have no effect on this trigger.

Top module: `instr_count_trigger`

## Requirements
- R1: While `rst` is high and one cycle after it, `rd_tdata1` reads as type 3 in bits XLEN-1:XLEN-4 with every other bit zero, and `fire` is low.
- R2: A write with `wr_en`=1 and `wr_sel`=1 loads the count from `wr_data` bits 23:10 and the enables from bits 9 (M), 7 (S), 6 (U), 25 (VU) and 26 (VS). The new value is visible on `rd_tdata1` after the next clock edge.
- R3: A `retire` pulse in an enabled mode with a non-zero count lowers the count by exactly one per clock.
- R4: A `retire` pulse in a mode whose enable bit is clear leaves the count unchanged. This includes `priv`=2, which has no enable, and M mode while `virt`=1.
- R5: `fire` goes high for exactly one cycle, on the same edge at which the count steps from 1 to 0.
- R6: With a count of zero, `retire` changes nothing and `fire` stays low.
- R7: With `virt`=0, the mode is selected by `priv` (0=U, 1=S, 3=M) against the U/S/M bits. With `virt`=1, only VU (for `priv`=0) and VS (for `priv`=1) are consulted.
- R8: A control-word write in the same cycle as `retire` takes the written count with no decrement and no fire.
- R9: A write with `wr_sel`=2 or 3, or with `wr_sel`=0, leaves the control word unchanged.
- R10: Bits outside the count and enable fields always read as type 3 in the top nibble and zero elsewhere, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 1 control word, 2 second data, 3 third data |
| wr_data | input | XLEN | Write data |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt | input | 1 | Hart is in a virtualized mode |
| rd_tdata1 | output | XLEN | Control word with live count |
| fire | output | 1 | Breakpoint request pulse |

## Verification
A control-word write and a counted retirement can land on the same clock edge. The bench provokes this by asserting `wr_en` and `retire` together in an enabled mode. It does so once while the held count is 1, which would otherwise fire. The case is judged on the next readback, which must show exactly the written count, with `fire` low. Around that case, a sweep covers all 32 enable masks against every `priv`/`virt` pair and compares the counted and uncounted results arithmetically.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

  // privilege encodings seen on the priv input
  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  // write target selection
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_AUX2 = 2'd2,
    SEL_AUX3 = 2'd3
  } wsel_e;

  // per-mode enable set held by the trigger
  typedef struct packed {
    logic vs;
    logic vu;
    logic m;
    logic s;
    logic u;
  } mode_en_t;

  // bit positions of the enable fields inside the control word
  localparam int unsigned POS_VS = 26;
  localparam int unsigned POS_VU = 25;
  localparam int unsigned POS_M  = 9;
  localparam int unsigned POS_S  = 7;
  localparam int unsigned POS_U  = 6;

  localparam logic [3:0] TRIG_KIND_ICOUNT = 4'd3;

endpackage

// File: rtl/tcnt_ctrl_decode.sv
module tcnt_ctrl_decode
  import tcnt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_LSB = 10,
  parameter int unsigned CNT_W   = 14
) (
  input  logic [XLEN-1:0]  word,
  output mode_en_t         en,
  output logic [CNT_W-1:0] cnt
);

  logic unused_word_bits;
  assign unused_word_bits = ^word;

  always_comb begin
    en.vs = word[POS_VS];
    en.vu = word[POS_VU];
    en.m  = word[POS_M];
    en.s  = word[POS_S];
    en.u  = word[POS_U];
    cnt   = word[CNT_LSB +: CNT_W];
  end

endmodule

// File: rtl/tcnt_mode_gate.sv
module tcnt_mode_gate
  import tcnt_pkg::*;
(
  input  mode_en_t   en,
  input  logic [1:0] priv,
  input  logic       virt,
  output logic       allow
);

  always_comb begin
    allow = 1'b0;
    if (virt) begin
      unique case (priv)
        PRV_U:   allow = en.vu;
        PRV_S:   allow = en.vs;
        default: allow = 1'b0;
      endcase
    end else begin
      unique case (priv)
        PRV_U:   allow = en.u;
        PRV_S:   allow = en.s;
        PRV_M:   allow = en.m;
        default: allow = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/tcnt_down_counter.sv
module tcnt_down_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic live;
  assign live = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      fire <= 1'b0;
    end else if (step && live) begin
      cnt  <= cnt - ONE;
      fire <= (cnt == ONE);
    end else begin
      fire <= 1'b0;
    end
  end

endmodule

// File: rtl/tcnt_word_pack.sv
module tcnt_word_pack
  import tcnt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_LSB = 10,
  parameter int unsigned CNT_W   = 14
) (
  input  mode_en_t         en,
  input  logic [CNT_W-1:0] cnt,
  output logic [XLEN-1:0]  word
);

  localparam int unsigned KIND_LSB = XLEN - 4;

  always_comb begin
    word                     = '0;
    word[KIND_LSB +: 4]      = TRIG_KIND_ICOUNT;
    word[CNT_LSB +: CNT_W]   = cnt;
    word[POS_VS]             = en.vs;
    word[POS_VU]             = en.vu;
    word[POS_M]              = en.m;
    word[POS_S]              = en.s;
    word[POS_U]              = en.u;
  end

endmodule

// File: rtl/instr_count_trigger.sv
module instr_count_trigger
  import tcnt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_LSB = 10,
  parameter int unsigned CNT_W   = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            retire,
  input  logic [1:0]      priv,
  input  logic            virt,
  output logic [XLEN-1:0] rd_tdata1,
  output logic            fire
);

  mode_en_t         wr_en_bits;
  logic [CNT_W-1:0] wr_cnt;
  mode_en_t         en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             allow;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  tcnt_ctrl_decode #(.XLEN(XLEN), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_dec (
    .word (wr_data),
    .en   (wr_en_bits),
    .cnt  (wr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (ctrl_wr) begin
      en_q <= wr_en_bits;
    end
  end

  tcnt_mode_gate u_gate (
    .en    (en_q),
    .priv  (priv),
    .virt  (virt),
    .allow (allow)
  );

  tcnt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ctrl_wr),
    .load_val (wr_cnt),
    .step     (retire && allow),
    .cnt      (cnt_q),
    .fire     (fire)
  );

  tcnt_word_pack #(.XLEN(XLEN), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_pack (
    .en   (en_q),
    .cnt  (cnt_q),
    .word (rd_tdata1)
  );

endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_LSB = 10,
  parameter int unsigned CNT_W   = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             retire,
  input logic [1:0]       priv,
  input logic             virt,
  input logic [XLEN-1:0]  rd_tdata1,
  input logic             fire
);

  localparam logic [XLEN-1:0] FIXED = XLEN'(3) << (XLEN - 4);
  localparam logic [XLEN-1:0] LIVE  =
      ((XLEN'(1) << CNT_W) - XLEN'(1)) << CNT_LSB |
      (XLEN'(1) << 26) | (XLEN'(1) << 25) | (XLEN'(1) << 9) |
      (XLEN'(1) << 7) | (XLEN'(1) << 6);

  logic [CNT_W-1:0] cnt_now;
  logic             mode_ok;
  logic             ctrl_wr;

  assign cnt_now = rd_tdata1[CNT_LSB +: CNT_W];
  assign ctrl_wr = wr_en && (wr_sel == 2'd1);

  always_comb begin
    if (virt)
      mode_ok = (priv == 2'd0) ? rd_tdata1[25] :
                (priv == 2'd1) ? rd_tdata1[26] : 1'b0;
    else
      mode_ok = (priv == 2'd0) ? rd_tdata1[6] :
                (priv == 2'd1) ? rd_tdata1[7] :
                (priv == 2'd3) ? rd_tdata1[9] : 1'b0;
  end

  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> cnt_now == $past(wr_cnt));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && retire && mode_ok && cnt_now != '0) |=> cnt_now == $past(cnt_now) - CNT_W'(1));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !(retire && mode_ok)) |=> $stable(cnt_now));

  a_r5_fire_at_zero: assert property (@(posedge clk) disable iff (rst)
    fire |-> cnt_now == '0);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !fire);

  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_tdata1 & ~LIVE) == FIXED);

endmodule

bind instr_count_trigger tcnt_checker #(.XLEN(XLEN), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_cnt    (wr_data[CNT_LSB +: CNT_W]),
  .retire    (retire),
  .priv      (priv),
  .virt      (virt),
  .rd_tdata1 (rd_tdata1),
  .fire      (fire)
);

// File: tb/sim_instr_count_trigger.sv
module sim_instr_count_trigger;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        retire = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic        virt = 1'b0;
  logic [31:0] rd_tdata1;
  logic        fire;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  instr_count_trigger u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .retire(retire), .priv(priv), .virt(virt), .rd_tdata1(rd_tdata1), .fire(fire)
  );

  // mask bit order: [0]U [1]S [2]M [3]VU [4]VS
  function automatic logic [31:0] mk(input int cnt, input logic [4:0] mask);
    logic [31:0] w;
    w = 32'h3000_0000;
    w[23:10] = cnt[13:0];
    w[6] = mask[0]; w[7] = mask[1]; w[9] = mask[2];
    w[25] = mask[3]; w[26] = mask[4];
    return w;
  endfunction

  function automatic bit counts(input logic [4:0] mask, input int p, input bit v);
    if (v) return (p == 0) ? mask[3] : (p == 1) ? mask[4] : 1'b0;
    return (p == 0) ? mask[0] : (p == 1) ? mask[1] : (p == 3) ? mask[2] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit we, input int sel, input logic [31:0] d,
                       input bit ret, input int p, input bit v);
    wr_en = we; wr_sel = sel[1:0]; wr_data = d; retire = ret;
    priv = p[1:0]; virt = v;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 0, 32'h0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_tdata1, 32'h3000_0000);
    chk("R1 reset fire", {31'd0, fire}, 32'd0);
    rst = 1'b0;
    idle();
    chk("R1 after reset", rd_tdata1, 32'h3000_0000);

    // R3 R4 R7 sweep: every mask against every mode
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int v = 0; v < 2; v++) begin
          drive(1, 1, mk(5, m[4:0]), 0, p, v[0]);
          chk("R2 load", rd_tdata1, mk(5, m[4:0]));
          drive(0, 0, 32'h0, 1, p, v[0]);
          chk(counts(m[4:0], p, v[0]) ? "R3 R7 counted" : "R4 R7 not counted",
              rd_tdata1, mk(counts(m[4:0], p, v[0]) ? 4 : 5, m[4:0]));
          chk("R5 no fire mid count", {31'd0, fire}, 32'd0);
        end
      end
    end

    // R5 firing sequence with an uncounted retire in between
    drive(1, 1, mk(3, 5'b00001), 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R3 3->2", rd_tdata1, mk(2, 5'b00001));
    drive(0, 0, 0, 1, 3, 0);
    chk("R4 M disabled", rd_tdata1, mk(2, 5'b00001));
    drive(0, 0, 0, 1, 0, 0);
    chk("R3 2->1", rd_tdata1, mk(1, 5'b00001));
    chk("R5 no early fire", {31'd0, fire}, 32'd0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R5 count zero", rd_tdata1, mk(0, 5'b00001));
    chk("R5 fire high", {31'd0, fire}, 32'd1);
    idle();
    chk("R5 fire one cycle", {31'd0, fire}, 32'd0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R6 zero stays", rd_tdata1, mk(0, 5'b00001));
    chk("R6 zero no fire", {31'd0, fire}, 32'd0);

    // R3 back-to-back retires, one per clock
    drive(1, 1, mk(2, 5'b00010), 0, 1, 0);
    drive(0, 0, 0, 1, 1, 0);
    chk("R3 b2b first", rd_tdata1, mk(1, 5'b00010));
    drive(0, 0, 0, 1, 1, 0);
    chk("R3 b2b second", rd_tdata1, mk(0, 5'b00010));
    chk("R5 b2b fire", {31'd0, fire}, 32'd1);

    // R8 write and retire in the same cycle
    drive(1, 1, mk(1, 5'b00100), 0, 3, 0);
    drive(1, 1, mk(7, 5'b00100), 1, 3, 0);
    chk("R8 write wins", rd_tdata1, mk(7, 5'b00100));
    chk("R8 no fire", {31'd0, fire}, 32'd0);
    drive(1, 1, mk(1, 5'b00100), 1, 3, 0);
    chk("R8 load one", rd_tdata1, mk(1, 5'b00100));
    chk("R8 load one no fire", {31'd0, fire}, 32'd0);

    // R9 writes to other targets are ignored
    drive(1, 1, mk(9, 5'b11111), 0, 0, 0);
    drive(1, 2, 32'h0000_0000, 0, 0, 0);
    chk("R9 sel2", rd_tdata1, mk(9, 5'b11111));
    drive(1, 3, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R9 sel3", rd_tdata1, mk(9, 5'b11111));
    drive(1, 0, 32'h0000_0000, 0, 0, 0);
    chk("R9 sel0", rd_tdata1, mk(9, 5'b11111));
    drive(0, 1, 32'h0000_0000, 0, 0, 0);
    chk("R9 no strobe", rd_tdata1, mk(9, 5'b11111));
    drive(0, 0, 0, 1, 0, 1);
    chk("R9 enables intact", rd_tdata1, mk(8, 5'b11111));

    // R10 fixed bits and the largest count
    drive(1, 1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R10 all ones", rd_tdata1, mk(16383, 5'b11111));
    drive(0, 0, 0, 1, 1, 0);
    chk("R3 max step", rd_tdata1, mk(16382, 5'b11111));
    drive(1, 1, 32'h0FFF_FC00 & ~32'h0700_02C0, 0, 0, 0);
    chk("R10 no enables", rd_tdata1, mk(16383, 5'b00000));
    drive(0, 0, 0, 1, 3, 0);
    chk("R4 none enabled", rd_tdata1, mk(16383, 5'b00000));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule